// File: doc/BRIEF.md
# Supervised-Supply Reset Sequencer

This block produces the active-low system reset for a supply supervisor. It takes one already-synchronized "supply good" flag per supervised rail, plus a decoded two-bit mode code. As soon as any rail is reported bad, the block pulls reset low. It releases reset only after every rail has been good without a break for a whole timeout. The timeout is counted in clock cycles. The mode code picks one of two lengths: a long internal one, derived from a 200 ms period at the clock frequency, or a shorter one given directly as a cycle count.

A third mode code freezes the reset output. This lets supply-margining tests push rails out of range without rebooting the system. When the freeze ends, the block follows rules that depend on two things: the level reset held when the freeze began, and the rail status at the moment of release. A high reset with all rails good at release stays high. A high reset with a bad rail at release falls after a short, parameterized delay. A low reset with all rails good at release waits a complete new timeout. The block comes out of its own synchronous reset in the frozen state with the output low.

Top module: `supply_reset_sequencer`

## Requirements
- R1: Outside the frozen mode and outside the release window, any flag of `mon_ok` at 0 at a clock edge drives `rst_n` low from that edge on.
- R2: `rst_n` rises only after every flag has been 1 for a number of consecutive qualifying edges equal to the selected timeout: `(CLK_HZ*TIMEOUT_MS)/1000` cycles for the internal timeout, `EXT_CYC` cycles for the external one.
- R3: A bad flag during a count clears the count, and reset stays low. Counting restarts from zero once all flags are good again.
- R4: `mode_code` is registered, so a new code takes effect one clock later. The encoding is 2'b00 frozen, 2'b01 external timeout, 2'b10 internal timeout, and 2'b11 also internal timeout.
- R5: While the registered mode is frozen, `rst_n` keeps its level whatever `mon_ok` does.
- R6: If `rst_n` was high when the freeze began and all flags are good at release, `rst_n` stays high and no timeout runs.
- R7: If `rst_n` was high when the freeze began and a flag is bad at release, `rst_n` stays high for `REL_DLY` edges after the registered mode leaves the frozen state, then falls on the next edge.
- R8: If `rst_n` was low when the freeze began and all flags are good at release, `rst_n` rises only after a complete new timeout counted from release. Any count made before the freeze is discarded.
- R9: When `srst` is high, the block enters the frozen mode with `rst_n` low. It stays low until `mode_code` selects a non-frozen mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Active-high synchronous reset of the block |
| mon_ok | input | NUM_MON | Synchronized supply-good flags, 1 = rail in range |
| mode_code | input | 2 | Decoded mode: 00 frozen, 01 external timeout, 10/11 internal timeout |
| rst_n | output | 1 | Active-low system reset |

## Verification
The bench builds the block with `CLK_HZ` = 250, `TIMEOUT_MS` = 200, `EXT_CYC` = 12 and `REL_DLY` = 3. With these values the internal timeout is 50 cycles, so a full internal count runs, and its exact edge can be checked, within a short run. The short external count makes it cheap to produce a glitch in the middle of a count and a partial count before a freeze. A release delay of 3 separates the delayed fall of R7 clearly from the immediate assertion of R1.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

   typedef enum logic [1:0] {
      RSQ_FROZEN  = 2'b00,
      RSQ_EXT     = 2'b01,
      RSQ_INT     = 2'b10,
      RSQ_INT_ALT = 2'b11
   } rsq_mode_e;

   function automatic logic mode_is_frozen(input rsq_mode_e m);
      return (m == RSQ_FROZEN);
   endfunction

   function automatic logic mode_is_ext(input rsq_mode_e m);
      return (m == RSQ_EXT);
   endfunction

endpackage

// File: rtl/rsq_mode_reg.sv
module rsq_mode_reg
   import rsq_pkg::*;
(
   input  logic       clk,
   input  logic       srst,
   input  logic [1:0] mode_code,
   output logic       frozen,
   output logic       ext_sel
);

   rsq_mode_e mode_q;

   always_ff @(posedge clk) begin
      if (srst) mode_q <= RSQ_FROZEN;
      else      mode_q <= rsq_mode_e'(mode_code);
   end

   assign frozen  = mode_is_frozen(mode_q);
   assign ext_sel = mode_is_ext(mode_q);

endmodule

// File: rtl/rsq_release_window.sv
module rsq_release_window #(
   parameter int REL_DLY = 2
) (
   input  logic clk,
   input  logic srst,
   input  logic frozen,
   output logic hold
);

   generate
      if (REL_DLY == 0) begin : g_no_window
         logic unused_win;
         assign unused_win = ^{clk, srst, frozen};
         assign hold = 1'b0;
      end else begin : g_window
         localparam int RW = $clog2(REL_DLY + 1);
         localparam logic [RW-1:0] LOAD = RW'(REL_DLY);
         logic [RW-1:0] left_q;

         always_ff @(posedge clk) begin
            if (srst)              left_q <= '0;
            else if (frozen)       left_q <= LOAD;
            else if (left_q != '0) left_q <= left_q - 1'b1;
         end

         assign hold = (left_q != '0);
      end
   endgenerate

endmodule

// File: rtl/rsq_timeout_ctr.sv
module rsq_timeout_ctr #(
   parameter int INT_CYC = 1000,
   parameter int EXT_CYC = 100
) (
   input  logic clk,
   input  logic srst,
   input  logic run,
   input  logic ext_sel,
   output logic expired
);

   localparam int MAXC = (INT_CYC > EXT_CYC) ? INT_CYC : EXT_CYC;
   localparam int CW   = $clog2(MAXC + 1);
   localparam logic [CW-1:0] LAST_INT = CW'(INT_CYC - 1);
   localparam logic [CW-1:0] LAST_EXT = CW'(EXT_CYC - 1);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] last;

   assign last = ext_sel ? LAST_EXT : LAST_INT;

   always_ff @(posedge clk) begin
      if (srst || !run)    cnt_q <= '0;
      else if (cnt_q <= last) cnt_q <= cnt_q + 1'b1;
   end

   assign expired = run && (cnt_q >= last);

endmodule

// File: rtl/supply_reset_sequencer.sv
module supply_reset_sequencer #(
   parameter int NUM_MON    = 3,
   parameter int CLK_HZ     = 50_000_000,
   parameter int TIMEOUT_MS = 200,
   parameter int EXT_CYC    = 20_000,
   parameter int REL_DLY    = 2
) (
   input  logic               clk,
   input  logic               srst,
   input  logic [NUM_MON-1:0] mon_ok,
   input  logic [1:0]         mode_code,
   output logic               rst_n
);

   localparam longint INT_L   = (longint'(CLK_HZ) * longint'(TIMEOUT_MS)) / 1000;
   localparam int     INT_CYC = int'(INT_L);
   localparam int     MIN_CYC = (INT_CYC < EXT_CYC) ? INT_CYC : EXT_CYC;

   generate
      if (NUM_MON < 1) begin : g_bad_mon
         $error("NUM_MON must be at least 1");
      end
      if (INT_CYC < 2) begin : g_bad_int
         $error("internal timeout must be at least 2 cycles");
      end
      if (EXT_CYC < 2) begin : g_bad_ext
         $error("EXT_CYC must be at least 2");
      end
      if (REL_DLY < 0) begin : g_bad_rel
         $error("REL_DLY must not be negative");
      end
   endgenerate

   logic frozen;
   logic ext_sel;
   logic hold;
   logic expired;
   logic all_ok;
   logic rst_q;
   logic run;

   assign all_ok = &mon_ok;
   assign run    = !frozen && all_ok && !rst_q;

   rsq_mode_reg u_mode (
      .clk       (clk),
      .srst      (srst),
      .mode_code (mode_code),
      .frozen    (frozen),
      .ext_sel   (ext_sel)
   );

   rsq_release_window #(.REL_DLY(REL_DLY)) u_win (
      .clk    (clk),
      .srst   (srst),
      .frozen (frozen),
      .hold   (hold)
   );

   rsq_timeout_ctr #(.INT_CYC(INT_CYC), .EXT_CYC(EXT_CYC)) u_tmo (
      .clk     (clk),
      .srst    (srst),
      .run     (run),
      .ext_sel (ext_sel),
      .expired (expired)
   );

   always_ff @(posedge clk) begin
      if (srst)         rst_q <= 1'b0;
      else if (frozen)  rst_q <= rst_q;
      else if (!all_ok) rst_q <= hold ? rst_q : 1'b0;
      else if (expired) rst_q <= 1'b1;
   end

   assign rst_n = rst_q;

endmodule

// File: rtl/rsq_checker.sv
module rsq_checker #(
   parameter int NUM_MON = 3,
   parameter int MIN_CYC = 2
) (
   input logic               clk,
   input logic               srst,
   input logic [NUM_MON-1:0] mon_ok,
   input logic [1:0]         mode_code,
   input logic               frozen,
   input logic               hold,
   input logic               rst_n
);

   int good_run;

   always_ff @(posedge clk) begin
      if (srst || frozen || !(&mon_ok)) good_run <= 0;
      else if (good_run < MIN_CYC)      good_run <= good_run + 1;
   end

   a_r1_bad_flag_asserts: assert property (@(posedge clk) disable iff (srst)
      (!frozen && !hold && !(&mon_ok)) |=> !rst_n);

   a_r2_rise_after_full_run: assert property (@(posedge clk) disable iff (srst)
      $rose(rst_n) |-> (good_run >= MIN_CYC));

   a_r4_mode_registered: assert property (@(posedge clk) disable iff (srst)
      1'b1 |=> (frozen == ($past(mode_code) == 2'b00)));

   a_r5_frozen_holds: assert property (@(posedge clk) disable iff (srst)
      frozen |=> $stable(rst_n));

   a_r7_window_defers_fall: assert property (@(posedge clk) disable iff (srst)
      (hold && !frozen) |=> !$fell(rst_n));

   a_r9_sync_reset_state: assert property (@(posedge clk)
      srst |=> (!rst_n && frozen));

endmodule

bind supply_reset_sequencer rsq_checker #(
   .NUM_MON (NUM_MON),
   .MIN_CYC (MIN_CYC)
) u_chk (
   .clk       (clk),
   .srst      (srst),
   .mon_ok    (mon_ok),
   .mode_code (mode_code),
   .frozen    (frozen),
   .hold      (hold),
   .rst_n     (rst_n)
);

// File: tb/sim_supply_reset_sequencer.sv
module sim_supply_reset_sequencer;

   localparam int NM   = 3;
   localparam int HZ   = 250;
   localparam int TMS  = 200;
   localparam int EXTC = 12;
   localparam int REL  = 3;
   localparam int INTC = (HZ * TMS) / 1000;

   logic          clk = 1'b0;
   logic          srst = 1'b1;
   logic [NM-1:0] mon_ok = '1;
   logic [1:0]    mode_code = 2'b10;
   logic          rst_n;

   int    n_checks = 0;
   int    n_fail   = 0;
   string phase    = "R9";
   bit    started  = 1'b0;
   bit    done     = 1'b0;

   always #10 clk = ~clk;

   supply_reset_sequencer #(
      .NUM_MON(NM), .CLK_HZ(HZ), .TIMEOUT_MS(TMS), .EXT_CYC(EXTC), .REL_DLY(REL)
   ) u0 (
      .clk(clk), .srst(srst), .mon_ok(mon_ok), .mode_code(mode_code), .rst_n(rst_n)
   );

   // behavioural reference, evaluated on each rising edge
   int m_mode = 0;
   int m_rst  = 0;
   int m_run  = 0;
   int m_win  = 0;

   always @(posedge clk) begin
      int  term;
      bit  was_frozen;
      bit  good;
      int  nxt;
      started    = 1'b1;
      was_frozen = (m_mode == 0);
      good       = (mon_ok == '1);
      if (srst) begin
         m_mode = 0; m_rst = 0; m_run = 0; m_win = 0;
      end else begin
         term = (m_mode == 1) ? EXTC : INTC;
         nxt  = m_rst;
         if (was_frozen)          nxt = m_rst;
         else if (!good)          nxt = (m_win > 0) ? m_rst : 0;
         else if (m_rst == 0 && m_run + 1 >= term) nxt = 1;
         if (was_frozen || !good || m_rst == 1) m_run = 0;
         else                                   m_run = m_run + 1;
         if (was_frozen)     m_win = REL;
         else if (m_win > 0) m_win = m_win - 1;
         m_rst  = nxt;
         m_mode = (mode_code == 2'b11) ? 2 : int'(mode_code);
      end
   end

   always @(negedge clk) begin
      if (started && !done) begin
         n_checks++;
         if (int'(rst_n) != m_rst) begin
            n_fail++;
            $display("FAIL %s per-cycle: rst_n actual=%0d expected=%0d at %0t",
                     phase, rst_n, m_rst, $time);
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #4;
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      #1;
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: rst_n actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run hung, actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : stim
      // R9: synchronous reset, then held frozen
      tick(3);
      chk("R9", rst_n, 1'b0);
      srst = 1'b0; mode_code = 2'b00;
      tick(20);
      chk("R9", rst_n, 1'b0);

      // R2 / R4: internal timeout after leaving the frozen mode
      phase = "R2";
      mode_code = 2'b10;
      tick(INTC);
      chk("R2", rst_n, 1'b0);
      tick(1);
      chk("R2", rst_n, 1'b1);

      // R1: one bad flag drops reset on the next edge
      phase = "R1";
      mon_ok = 3'b101;
      tick(1);
      chk("R1", rst_n, 1'b0);
      mon_ok = '1;

      // R3: glitch in the middle of an external count
      phase = "R3";
      mode_code = 2'b01;
      tick(8);
      mon_ok = 3'b011;
      tick(1);
      chk("R3", rst_n, 1'b0);
      mon_ok = '1;
      tick(EXTC - 1);
      chk("R3", rst_n, 1'b0);
      tick(1);
      chk("R3", rst_n, 1'b1);

      // R5 / R6: frozen high, flags bad during freeze, good at release
      phase = "R5";
      mode_code = 2'b00;
      tick(2);
      mon_ok = 3'b110;
      tick(5);
      chk("R5", rst_n, 1'b1);
      mon_ok = '1;
      tick(3);
      phase = "R6";
      mode_code = 2'b10;
      tick(10);
      chk("R6", rst_n, 1'b1);

      // R7: frozen high, a flag bad at release
      phase = "R7";
      mode_code = 2'b00;
      tick(2);
      mon_ok = 3'b110;
      tick(3);
      mode_code = 2'b10;
      tick(REL + 1);
      chk("R7", rst_n, 1'b1);
      tick(1);
      chk("R7", rst_n, 1'b0);

      // R8: frozen low with a partial count, good at release
      phase = "R8";
      mode_code = 2'b01; mon_ok = '1;
      tick(5);
      mode_code = 2'b00;
      tick(6);
      mode_code = 2'b01;
      tick(EXTC);
      chk("R8", rst_n, 1'b0);
      tick(1);
      chk("R8", rst_n, 1'b1);

      // R4: code 11 selects the internal timeout
      phase = "R4";
      mon_ok = 3'b011;
      tick(1);
      chk("R4", rst_n, 1'b0);
      mon_ok = '1; mode_code = 2'b11;
      tick(INTC - 1);
      chk("R4", rst_n, 1'b0);
      tick(1);
      chk("R4", rst_n, 1'b1);

      tick(2);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule